// File: doc/BRIEF.md
# Command-mapped flash access decoder

This block sits between an on-chip bus and a flash-side sequencer. Every bus access lands in one 32-bit address window, and the window encodes both the kind of operation and where in the flash it goes. Two address bits pick one of four access maps: two register maps (half-word and word granularity), a page-data stream map and a command map. The remaining low bits carry either a register address or a block, page and sector location. A parameter selects one of two location layouts, a wide one and a narrow one.

For the command map, the written data value is an opcode. The block turns it into a compact operation code: erase, the ends of the unlock, lock and lock-tight ranges, or unlock-all. An unknown opcode, or a read of the command map, issues nothing and sets a sticky flag. For the stream map, repeated accesses to one address walk through the words of a page. The block numbers each word, marks the words that fall in the spare area and pulses a done flag on the last word. Each accepted access produces one registered request toward the sequencer in the next cycle.

Top module: `flash_access_decoder`

## Requirements
- R1: `bus_addr[25:24]` selects the map: 00 half-word register map, 01 page stream, 10 command, 11 word register map. `req_kind` reports the same two-bit code. Address bits [31:26] have no effect.
- R2: A map 00 access issues a request with `req_reg` = `bus_addr[16:1]`. The access direction goes to `req_write` and the bus data to `req_data`.
- R3: A map 11 access issues a request with `req_reg` = `bus_addr[17:2]`.
- R4: With the default wide layout (NARROW=0), the sector is `bus_addr[5:4]`, the page is `bus_addr[11:6]` and the block is `bus_addr[23:12]`.
- R5: With NARROW=1, the sector is `bus_addr[3:2]`, the page is `bus_addr[9:4]` and the block is `bus_addr[21:10]`.
- R6: A map 10 write with data 0x03, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D or 0x0E issues a request with `cmd_op` = 1 to 8 in that order. The meanings are erase, unlock start, unlock end, lock start, lock end, tight start, tight end and unlock all. Every other request carries `cmd_op` = 0.
- R7: A map 10 write with any other value, or any map 10 read, issues no request and leaves every payload output unchanged. It sets `illegal_cmd`, which stays set until reset.
- R8: The first stream beat, or a stream beat whose block/page/sector differs from the previous stream beat, gets `word_idx` 0. A beat to the same location gets the next index. Beats of other maps in between do not disturb the count.
- R9: `spare_en` is sampled only on the first beat of a page. When it is set the page spans MAIN_WORDS+SPARE_WORDS words, otherwise MAIN_WORDS. `in_spare` is 1 exactly on words with index at least MAIN_WORDS.
- R10: `stream_done` pulses with the request of the last word of a page. The next stream beat, even at the same address, starts again at index 0.
- R11: A request appears one cycle after the accepted access. `req_valid` and `stream_done` are low in every other cycle, and the payload outputs hold their last value.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Bus address |
| bus_wdata | input | 32 | Bus write data |
| spare_en | input | 1 | Include spare area in a new page stream |
| req_valid | output | 1 | Request to sequencer |
| req_kind | output | 2 | Map code of the request |
| req_write | output | 1 | Direction of the request |
| req_block | output | BLK_W | Block address |
| req_page | output | PG_W | Page address |
| req_sector | output | SEC_W | Sector address |
| req_reg | output | REG_W | Register word address |
| req_data | output | 32 | Data forwarded from the bus |
| cmd_op | output | 4 | Decoded command operation |
| word_idx | output | IDX_W | Word position within the page stream |
| in_spare | output | 1 | Current word lies in the spare area |
| stream_done | output | 1 | Last word of the page |
| illegal_cmd | output | 1 | Sticky unknown-command flag |

## Verification
Two functions can meet in one cycle: the end of a page and the start of a new one. The bench streams a page to one word short of its end and then sends a beat to a new location. That beat must restart at index 0 with no done pulse. A beat at the old address right after a completed page must also restart. Command and register beats are also interleaved between stream beats, and an illegal opcode is placed right next to valid requests. A behavioural reference model in the bench predicts every output on every clock and judges all of these cases.

// File: rtl/fad_pkg.sv
package fad_pkg;

  localparam int MAP_LSB = 24;

  typedef enum logic [1:0] {
    MAP_REG_HALF = 2'b00,
    MAP_STREAM   = 2'b01,
    MAP_CMD      = 2'b10,
    MAP_REG_WORD = 2'b11
  } map_e;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_ERASE    = 4'd1,
    OP_UNLK_BEG = 4'd2,
    OP_UNLK_END = 4'd3,
    OP_LOCK_BEG = 4'd4,
    OP_LOCK_END = 4'd5,
    OP_TGHT_BEG = 4'd6,
    OP_TGHT_END = 4'd7,
    OP_UNLK_ALL = 4'd8
  } op_e;

endpackage

// File: rtl/fad_field_split.sv
module fad_field_split #(
  parameter int NARROW = 0,
  parameter int BLK_W  = 12,
  parameter int PG_W   = 6,
  parameter int SEC_W  = 2,
  parameter int REG_W  = 16
) (
  input  logic [31:0]      addr,
  output logic [BLK_W-1:0] blk,
  output logic [PG_W-1:0]  pg,
  output logic [SEC_W-1:0] sec,
  output logic [REG_W-1:0] reg_half,
  output logic [REG_W-1:0] reg_word
);

  // location layout chosen by variant
  generate
    if (NARROW != 0) begin : g_narrow
      localparam int SEC_SH = 2;
      localparam int PG_SH  = SEC_SH + SEC_W;
      localparam int BLK_SH = PG_SH + PG_W;
      assign sec = addr[SEC_SH +: SEC_W];
      assign pg  = addr[PG_SH  +: PG_W];
      assign blk = addr[BLK_SH +: BLK_W];
    end else begin : g_wide
      localparam int SEC_SH = 4;
      localparam int PG_SH  = SEC_SH + SEC_W;
      localparam int BLK_SH = PG_SH + PG_W;
      assign sec = addr[SEC_SH +: SEC_W];
      assign pg  = addr[PG_SH  +: PG_W];
      assign blk = addr[BLK_SH +: BLK_W];
    end
  endgenerate

  // register maps: byte address scaled by 2 or by 4
  assign reg_half = addr[1 +: REG_W];
  assign reg_word = addr[2 +: REG_W];

  logic unused_addr;
  assign unused_addr = ^addr;

endmodule

// File: rtl/fad_cmd_decode.sv
module fad_cmd_decode
  import fad_pkg::*;
(
  input  logic [31:0] code,
  output op_e         op,
  output logic        known
);

  always_comb begin
    known = 1'b1;
    case (code)
      32'h0000_0003: op = OP_ERASE;
      32'h0000_0008: op = OP_UNLK_BEG;
      32'h0000_0009: op = OP_UNLK_END;
      32'h0000_000A: op = OP_LOCK_BEG;
      32'h0000_000B: op = OP_LOCK_END;
      32'h0000_000C: op = OP_TGHT_BEG;
      32'h0000_000D: op = OP_TGHT_END;
      32'h0000_000E: op = OP_UNLK_ALL;
      default: begin
        op    = OP_NONE;
        known = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fad_stream_ctr.sv
module fad_stream_ctr #(
  parameter int MAIN_WORDS  = 1024,
  parameter int SPARE_WORDS = 32,
  parameter int LOC_W       = 20,
  localparam int TOTAL      = MAIN_WORDS + SPARE_WORDS,
  localparam int IDX_W      = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [LOC_W-1:0] loc,
  input  logic             spare_req,
  output logic [IDX_W-1:0] idx,
  output logic             in_spare,
  output logic             last
);

  localparam logic [IDX_W-1:0] LAST_MAIN = IDX_W'(MAIN_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_ALL  = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] SPARE_LO  = IDX_W'(MAIN_WORDS);

  logic             active_q, active_d;
  logic [LOC_W-1:0] loc_q, loc_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             spare_q, spare_d;
  logic             restart, spare_sel;

  // current beat
  always_comb begin
    restart   = !active_q || (loc != loc_q);
    idx       = restart ? '0 : cnt_q;
    spare_sel = restart ? spare_req : spare_q;
    last      = spare_sel ? (idx == LAST_ALL) : (idx == LAST_MAIN);
    in_spare  = (idx >= SPARE_LO);
  end

  // next state
  always_comb begin
    active_d = active_q;
    loc_d    = loc_q;
    cnt_d    = cnt_q;
    spare_d  = spare_q;
    if (beat) begin
      active_d = !last;
      loc_d    = loc;
      cnt_d    = last ? '0 : idx + 1'b1;
      spare_d  = spare_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      loc_q    <= '0;
      cnt_q    <= '0;
      spare_q  <= 1'b0;
    end else if (beat) begin
      active_q <= active_d;
      loc_q    <= loc_d;
      cnt_q    <= cnt_d;
      spare_q  <= spare_d;
    end
  end

  // an open stream always sits strictly inside its page
  p_cnt_in_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q != '0) && (cnt_q <= (spare_q ? LAST_ALL : LAST_MAIN)));

  // a finished page closes the stream
  p_close_on_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last) |=> !active_q);

endmodule

// File: rtl/flash_access_decoder.sv
module flash_access_decoder
  import fad_pkg::*;
#(
  parameter int NARROW      = 0,
  parameter int BLK_W       = 12,
  parameter int PG_W        = 6,
  parameter int SEC_W       = 2,
  parameter int REG_W       = 16,
  parameter int MAIN_WORDS  = 1024,
  parameter int SPARE_WORDS = 32,
  localparam int IDX_W      = $clog2(MAIN_WORDS + SPARE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [31:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             spare_en,
  output logic             req_valid,
  output logic [1:0]       req_kind,
  output logic             req_write,
  output logic [BLK_W-1:0] req_block,
  output logic [PG_W-1:0]  req_page,
  output logic [SEC_W-1:0] req_sector,
  output logic [REG_W-1:0] req_reg,
  output logic [31:0]      req_data,
  output logic [3:0]       cmd_op,
  output logic [IDX_W-1:0] word_idx,
  output logic             in_spare,
  output logic             stream_done,
  output logic             illegal_cmd
);

  localparam int LOC_W = BLK_W + PG_W + SEC_W;

  map_e             map_sel;
  logic [BLK_W-1:0] f_blk;
  logic [PG_W-1:0]  f_pg;
  logic [SEC_W-1:0] f_sec;
  logic [REG_W-1:0] f_rhalf, f_rword;
  op_e              c_op;
  logic             c_known;
  logic [IDX_W-1:0] s_idx;
  logic             s_spare, s_last;
  logic             beat, bad_cmd, issue;

  assign map_sel = map_e'(bus_addr[MAP_LSB +: 2]);

  fad_field_split #(
    .NARROW (NARROW),
    .BLK_W  (BLK_W),
    .PG_W   (PG_W),
    .SEC_W  (SEC_W),
    .REG_W  (REG_W)
  ) u_split (
    .addr     (bus_addr),
    .blk      (f_blk),
    .pg       (f_pg),
    .sec      (f_sec),
    .reg_half (f_rhalf),
    .reg_word (f_rword)
  );

  fad_cmd_decode u_cmd (
    .code  (bus_wdata),
    .op    (c_op),
    .known (c_known)
  );

  assign beat    = bus_valid && (map_sel == MAP_STREAM);
  assign bad_cmd = bus_valid && (map_sel == MAP_CMD) && !(bus_write && c_known);
  assign issue   = bus_valid && !bad_cmd;

  fad_stream_ctr #(
    .MAIN_WORDS  (MAIN_WORDS),
    .SPARE_WORDS (SPARE_WORDS),
    .LOC_W       (LOC_W)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .loc       ({f_blk, f_pg, f_sec}),
    .spare_req (spare_en),
    .idx       (s_idx),
    .in_spare  (s_spare),
    .last      (s_last)
  );

  // next-state values
  logic             valid_d, done_d, ill_d, spare_d;
  logic [REG_W-1:0] reg_d;
  op_e              op_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    valid_d = issue;
    done_d  = beat && s_last;
    ill_d   = illegal_cmd || bad_cmd;
    reg_d   = (map_sel == MAP_REG_WORD) ? f_rword : f_rhalf;
    op_d    = (map_sel == MAP_CMD) ? c_op : OP_NONE;
    idx_d   = beat ? s_idx : '0;
    spare_d = beat && s_spare;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid   <= 1'b0;
      stream_done <= 1'b0;
      illegal_cmd <= 1'b0;
      req_kind    <= '0;
      req_write   <= 1'b0;
      req_block   <= '0;
      req_page    <= '0;
      req_sector  <= '0;
      req_reg     <= '0;
      req_data    <= '0;
      cmd_op      <= '0;
      word_idx    <= '0;
      in_spare    <= 1'b0;
    end else begin
      req_valid   <= valid_d;
      stream_done <= done_d;
      illegal_cmd <= ill_d;
      if (issue) begin
        req_kind   <= bus_addr[MAP_LSB +: 2];
        req_write  <= bus_write;
        req_block  <= f_blk;
        req_page   <= f_pg;
        req_sector <= f_sec;
        req_reg    <= reg_d;
        req_data   <= bus_wdata;
        cmd_op     <= op_d;
        word_idx   <= idx_d;
        in_spare   <= spare_d;
      end
    end
  end

  // done only accompanies a stream request
  p_done_is_stream_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |-> req_valid && (req_kind == 2'b01));

  // after a page ends the next cycle cannot continue its count
  p_restart_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |=> !(req_valid && (req_kind == 2'b01) && (word_idx != '0)));

  // illegal flag never falls outside reset
  p_sticky_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |=> illegal_cmd);

  // a rejected command produces no request
  p_reject_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (map_sel == MAP_CMD) && !(bus_write && c_known)) |=> !req_valid);

  // command requests always carry an operation
  p_cmd_has_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 2'b10)) |-> (cmd_op != 4'd0));

  // non-command accesses always answer next cycle
  p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (map_sel != MAP_CMD)) |=> req_valid);

  // a page without spare ends on the last main word
  p_main_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_done && !in_spare) |-> (word_idx == IDX_W'(MAIN_WORDS - 1)));

endmodule

// File: tb/flash_access_decoder_bench.sv
`timescale 1ns/1ps
module flash_access_decoder_bench;

  localparam int MAINW = 1024;
  localparam int SPRW  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        spare_en = 1'b0;

  always #2 clk = ~clk;

  logic        req_valid, req_write, in_spare, stream_done, illegal_cmd;
  logic [1:0]  req_kind;
  logic [11:0] req_block;
  logic [5:0]  req_page;
  logic [1:0]  req_sector;
  logic [15:0] req_reg;
  logic [31:0] req_data;
  logic [3:0]  cmd_op;
  logic [10:0] word_idx;

  flash_access_decoder u_flash_access_decoder (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .spare_en(spare_en),
    .req_valid(req_valid), .req_kind(req_kind), .req_write(req_write),
    .req_block(req_block), .req_page(req_page), .req_sector(req_sector),
    .req_reg(req_reg), .req_data(req_data), .cmd_op(cmd_op),
    .word_idx(word_idx), .in_spare(in_spare), .stream_done(stream_done),
    .illegal_cmd(illegal_cmd)
  );

  // narrow layout, short pages
  logic        n_valid, n_write, n_spare, n_done, n_ill;
  logic [1:0]  n_kind;
  logic [11:0] n_block;
  logic [5:0]  n_page;
  logic [1:0]  n_sector;
  logic [15:0] n_reg;
  logic [31:0] n_data;
  logic [3:0]  n_op;
  logic [2:0]  n_idx;

  flash_access_decoder #(.NARROW(1), .MAIN_WORDS(4), .SPARE_WORDS(2)) u_flash_access_decoder_nar (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .spare_en(spare_en),
    .req_valid(n_valid), .req_kind(n_kind), .req_write(n_write),
    .req_block(n_block), .req_page(n_page), .req_sector(n_sector),
    .req_reg(n_reg), .req_data(n_data), .cmd_op(n_op),
    .word_idx(n_idx), .in_spare(n_spare), .stream_done(n_done),
    .illegal_cmd(n_ill)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit run_cmp = 0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int op_of(input logic [31:0] c);
    case (c)
      32'h03: return 1;
      32'h08: return 2;
      32'h09: return 3;
      32'h0A: return 4;
      32'h0B: return 5;
      32'h0C: return 6;
      32'h0D: return 7;
      32'h0E: return 8;
      default: return -1;
    endcase
  endfunction

  // reference model (wide layout, default sizes)
  int e_valid, e_kind, e_write, e_blk, e_pg, e_sec, e_reg, e_op, e_idx, e_spare, e_done, e_ill;
  longint e_data;
  int m_active, m_cnt, m_total, m_loc;
  string e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid = 0; e_kind = 0; e_write = 0; e_blk = 0; e_pg = 0; e_sec = 0;
      e_reg = 0; e_op = 0; e_idx = 0; e_spare = 0; e_done = 0; e_ill = 0; e_data = 0;
      m_active = 0; m_cnt = 0; m_total = 0; m_loc = 0; e_tag = "R12";
    end else begin
      e_valid = 0; e_done = 0; e_tag = "R11";
      if (bus_valid) begin
        int mp, a;
        a  = int'(bus_addr);
        mp = (a >> 24) & 3;
        if (mp == 2 && (!bus_write || op_of(bus_wdata) < 0)) begin
          e_ill = 1; e_tag = "R7";
        end else begin
          e_valid = 1; e_kind = mp; e_write = int'(bus_write); e_data = longint'(bus_wdata);
          e_sec = (a >> 4) & 3; e_pg = (a >> 6) & 63; e_blk = (a >> 12) & 4095;
          e_reg = (mp == 3) ? ((a >> 2) & 16'hFFFF) : ((a >> 1) & 16'hFFFF);
          e_op = (mp == 2) ? op_of(bus_wdata) : 0;
          e_idx = 0; e_spare = 0;
          case (mp)
            0: e_tag = "R2";
            3: e_tag = "R3";
            2: e_tag = "R6";
            default: begin
              int loc;
              loc = (a >> 4) & 20'hFFFFF;
              if (!m_active || loc != m_loc) begin
                m_cnt = 0; m_total = MAINW + (spare_en ? SPRW : 0);
              end
              e_idx = m_cnt; e_spare = (m_cnt >= MAINW);
              e_done = (m_cnt == m_total - 1);
              m_active = !e_done; m_cnt++; m_loc = loc;
              e_tag = e_done ? "R10" : (e_spare ? "R9" : "R8");
            end
          endcase
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      checks++;
      if (int'(req_valid) != e_valid || int'(req_kind) != e_kind || int'(req_write) != e_write ||
          int'(req_block) != e_blk || int'(req_page) != e_pg || int'(req_sector) != e_sec ||
          int'(req_reg) != e_reg || longint'(req_data) != e_data || int'(cmd_op) != e_op ||
          int'(word_idx) != e_idx || int'(in_spare) != e_spare || int'(stream_done) != e_done ||
          int'(illegal_cmd) != e_ill) begin
        errors++;
        $display("FAIL %s t=%0t actual v%0d k%0d w%0d b%0h p%0h s%0h r%0h d%0h op%0d i%0d sp%0d dn%0d il%0d expected v%0d k%0d w%0d b%0h p%0h s%0h r%0h d%0h op%0d i%0d sp%0d dn%0d il%0d",
          e_tag, $time, req_valid, req_kind, req_write, req_block, req_page, req_sector, req_reg,
          req_data, cmd_op, word_idx, in_spare, stream_done, illegal_cmd,
          e_valid, e_kind, e_write, e_blk, e_pg, e_sec, e_reg, e_data, e_op, e_idx, e_spare,
          e_done, e_ill);
      end
    end
  end

  task automatic beat(input logic w, input logic [31:0] a, input logic [31:0] d, input logic sp);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d; spare_en = sp;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_valid = 1'b0;
    end
  endtask

  function automatic logic [31:0] loc_w(input int blk, input int pg, input int sec);
    return 32'h0100_0000 | 32'(blk << 12) | 32'(pg << 6) | 32'(sec << 4);
  endfunction

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    logic [31:0] a, na, nb;
    repeat (3) @(negedge clk);
    chk("R12", "req_valid", req_valid, 0);
    chk("R12", "illegal_cmd", illegal_cmd, 0);
    chk("R12", "word_idx", word_idx, 0);
    chk("R12", "req_data", req_data, 0);
    rst_n = 1'b1;
    run_cmp = 1;

    // register maps, upper bits set
    beat(1, 32'hFC00_0246, 32'hDEAD_BEEF, 0);
    idle(1);
    chk("R1", "kind with high bits", req_kind, 0);
    chk("R2", "half reg", req_reg, 16'h0123);
    chk("R2", "data", req_data, 32'hDEAD_BEEF);
    beat(0, 32'h0300_048C, 32'h0, 0);
    idle(1);
    chk("R3", "word reg", req_reg, 16'h0123);
    idle(2);
    chk("R11", "valid low when idle", req_valid, 0);
    chk("R11", "payload holds", req_reg, 16'h0123);

    // full main-only page
    a = loc_w(5, 3, 2);
    beat(1, a, 32'h1, 0);
    idle(1);
    chk("R4", "block", req_block, 5);
    chk("R4", "page", req_page, 3);
    chk("R4", "sector", req_sector, 2);
    for (int i = 1; i < MAINW; i++) beat(1, a, 32'(i), 0);
    idle(1);
    chk("R10", "done at last main word", stream_done, 1);
    chk("R10", "last index", word_idx, MAINW - 1);
    beat(1, a, 32'h0, 0);
    idle(1);
    chk("R10", "restart after page", word_idx, 0);

    // page with spare, flag dropped after first beat
    a = loc_w(9, 1, 0);
    for (int i = 0; i < MAINW + SPRW; i++) beat(0, a, 32'h0, (i == 0));
    idle(1);
    chk("R9", "done at last spare word", stream_done, 1);
    chk("R9", "in spare", in_spare, 1);

    // new location one word before the end
    a = loc_w(2, 2, 2);
    for (int i = 0; i < MAINW - 1; i++) beat(1, a, 32'h0, 0);
    beat(1, loc_w(2, 2, 3), 32'h0, 0);
    idle(1);
    chk("R8", "restart on new location", word_idx, 0);
    chk("R8", "no done on restart", stream_done, 0);

    // interleaved maps, gaps
    a = loc_w(4, 4, 1);
    beat(0, a, 32'h0, 0);
    beat(1, 32'h0200_7000, 32'h03, 0);
    idle(1);
    beat(0, 32'h0000_0010, 32'h0, 0);
    beat(0, a, 32'h0, 0);
    idle(1);
    chk("R8", "count kept across other maps", word_idx, 1);

    // all command codes
    for (int k = 0; k < 8; k++) begin
      logic [31:0] code;
      code = (k == 0) ? 32'h03 : 32'(8 + k - 1);
      beat(1, 32'h0200_7000, code, 0);
      idle(1);
      chk("R6", "cmd_op", cmd_op, k + 1);
      chk("R6", "cmd block", req_block, 7);
    end
    beat(1, 32'h0200_3000, 32'h05, 0);
    idle(1);
    chk("R7", "unknown opcode no request", req_valid, 0);
    chk("R7", "illegal set", illegal_cmd, 1);
    chk("R7", "payload kept", cmd_op, 8);
    beat(0, 32'h0200_0000, 32'h03, 0);
    beat(1, 32'h0000_0002, 32'h0, 0);
    idle(1);
    chk("R7", "illegal sticky", illegal_cmd, 1);

    // narrow layout
    na = 32'h0100_0000 | (13 << 10) | (9 << 4) | (1 << 2);
    beat(1, na, 32'h0, 0);
    idle(1);
    chk("R5", "narrow block", n_block, 13);
    chk("R5", "narrow page", n_page, 9);
    chk("R5", "narrow sector", n_sector, 1);
    for (int i = 1; i < 4; i++) beat(1, na, 32'h0, 0);
    idle(1);
    chk("R10", "narrow done", n_done, 1);
    chk("R10", "narrow last idx", n_idx, 3);
    nb = 32'h0100_0000 | (21 << 10) | (2 << 4);
    for (int i = 0; i < 5; i++) beat(0, nb, 32'h0, (i == 0));
    idle(1);
    chk("R9", "narrow spare word", n_spare, 1);
    chk("R9", "narrow not done yet", n_done, 0);
    beat(0, nb, 32'h0, 0);
    idle(1);
    chk("R9", "narrow done with spare", n_done, 1);
    chk("R9", "narrow spare last idx", n_idx, 5);

    idle(3);
    finish_run();
  end

endmodule